// File: doc/BRIEF.md
# SPI Target Register Bridge

This block lets an external SPI host (mode 0, frames delimited by an active-low chip select) read and write 32-bit registers on an internal bus. Every frame opens with a 24-bit header sent most significant bit first. Its top bit selects write (1) or read (0), and the low 23 bits carry a word address, which is the byte address divided by four. A write frame carries one 32-bit data word right after the header. A read frame carries a programmable number of padding bytes after the header. The bridge ignores these bytes and spends them fetching the register. It then shifts the 32-bit result out on MISO. Each frame moves exactly one register.

The SPI pins are brought into the system clock domain through synchronizers and are sampled on detected SCLK edges. The system clock must therefore run well above twice the SCLK rate. Two word addresses, CFG_BASE and CFG_BASE+1, are served locally by configuration registers:
- The format register selects the byte order and bit order of the data word. The header is never affected by it.
- The interface status register holds the padding count, a sticky flag that records a read whose data came too late, and a fixed interface number.

All other addresses go out on a request/acknowledge port with arbitrary latency.

Top module: `spi_reg_bridge`

## Requirements
- R1: The first 24 SCLK rising edges of a frame carry the header, MSB first. Header bit 23 = 1 means write and 0 means read. Header bits 22:0 are the word address, and that exact value appears on bus_addr for the request.
- R2: In a write frame, the 32 bits after the header form the data word. Once the 56th bit is sampled, one bus write is issued. bus_we, bus_addr and bus_wdata stay stable until the cycle after bus_ack.
- R3: In a read frame, bus_re is raised right after the last header bit is sampled and is held until bus_ack. N padding bytes (N = status register bits 3:0) follow the header, and their MOSI content is ignored. The 32 data bits are then driven on MISO, each changing after a falling SCLK edge, so the host samples them on rising edges 24+8N to 24+8N+31.
- R4: The data word travels in 4 byte slots; serial bit k lies in slot k/8 at position k%8. Format bit 0 = 1 sends byte 3 in slot 0 (big-endian), and 0 sends byte 0 first. Format bit 1 = 1 sends each byte LSB first, and 0 sends it MSB first. All four settings apply to both directions.
- R5: Word address CFG_BASE is the format register. A write keeps the decoded bits 1:0. A read returns {30'b0, format}. A write whose every byte is {m0,m1,0,0,0,0,m1,m0} sets format m whatever format was active before the write.
- R6: Word address CFG_BASE+1 is the status register. A write sets the padding count from bits 3:0. A read returns 8'd2 in bits 31:24, the sticky flag in bit 16, the padding count in bits 3:0, and zero elsewhere.
- R7: If the read data has not arrived when the first payload bit must be driven, the bridge sends 32 zero bits and sets the sticky flag. The flag stays set until the status register is written with bit 16 = 1. Writing bit 16 = 0 leaves it unchanged.
- R8: If chip select rises before all 56 bits of a write frame have been sampled, nothing is written. The next frame decodes from bit 0.
- R9: Reset (rst high at a clock edge) sets format 0, padding 0 and sticky flag 0, clears both bus requests and holds MISO low.
- R10: Accesses to CFG_BASE and CFG_BASE+1 never raise bus_re or bus_we.
- R11: MISO is low while chip select is high and throughout the header and padding of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| bus_addr | output | HDR_W-1 | Register word address |
| bus_wdata | output | 32 | Register write data |
| bus_we | output | 1 | Write request, held until bus_ack |
| bus_re | output | 1 | Read request, held until bus_ack |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | One-cycle completion of the request |

## Verification
The hardest case to reach is the overrun. It needs a read whose bus acknowledge lands after the bridge has committed to the first payload bit, while a nearly identical read with a bit more padding must still succeed. The bench's bus model has a latency it can change at run time. One read uses zero padding with a 40-cycle latency, another uses one padding byte with a 30-cycle latency, and the sticky flag is then read back and cleared over SPI. The format-independent control write is reached by always sending the replicated control word serialized in format 0, whatever format the bridge is currently using.

// File: rtl/spi_reg_bridge_pkg.sv
`timescale 1ns/1ps
package spi_reg_bridge_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_LE_MSBF = 2'b00,
    FMT_BE_MSBF = 2'b01,
    FMT_LE_LSBF = 2'b10,
    FMT_BE_LSBF = 2'b11
  } wire_fmt_e;

  // Word bit carried by serial position k (k = 0 is the first bit on the line).
  function automatic logic [4:0] wire_idx(input logic [1:0] fmt, input logic [4:0] k);
    logic [1:0] slot;
    logic [2:0] pos;
    slot = fmt[0] ? ~k[4:3] : k[4:3];
    pos  = fmt[1] ? k[2:0] : ~k[2:0];
    return {slot, pos};
  endfunction

  // Word -> serial order, bit 31 of the result goes out first.
  function automatic logic [WORD_W-1:0] to_wire(input logic [1:0] fmt,
                                                 input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] w;
    logic [4:0] kk;
    w = '0;
    for (int k = 0; k < WORD_W; k++) begin
      kk = 5'(k);
      w[~kk] = word[wire_idx(fmt, kk)];
    end
    return w;
  endfunction

  // Serial order -> word.
  function automatic logic [WORD_W-1:0] from_wire(input logic [1:0] fmt,
                                                   input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] word;
    logic [4:0] kk;
    word = '0;
    for (int k = 0; k < WORD_W; k++) begin
      kk = 5'(k);
      word[wire_idx(fmt, kk)] = w[~kk];
    end
    return word;
  endfunction

endpackage

// File: rtl/spi_reg_bridge_sync.sv
`timescale 1ns/1ps
module spi_reg_bridge_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_reg_bridge_cfg.sv
`timescale 1ns/1ps
module spi_reg_bridge_cfg #(
  parameter int unsigned PAD_W = 4,
  parameter int unsigned IF_ID = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_stat,   // 1: status register, 0: format register
  input  logic [1:0]       wr_fmt,
  input  logic [PAD_W-1:0] wr_pad,
  input  logic             wr_clr,
  input  logic             set_flag,
  input  logic             rd_stat,
  output logic [1:0]       fmt,
  output logic [PAD_W-1:0] pad,
  output logic             flag,
  output logic [31:0]      rd_word
);
  logic [31:0] stat_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt  <= 2'b00;
      pad  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_en && !wr_stat) fmt <= wr_fmt;
      if (wr_en && wr_stat)  pad <= wr_pad;
      if (set_flag)                         flag <= 1'b1;
      else if (wr_en && wr_stat && wr_clr)  flag <= 1'b0;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[31:24] = 8'(IF_ID);
    stat_word[16] = flag;
    stat_word[PAD_W-1:0] = pad;
    rd_word = rd_stat ? stat_word : {30'b0, fmt};
  end

  // R7: the flag only rises after an overrun event
  a_r7_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set_flag));
  // R7: the flag holds unless explicitly cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && wr_stat && wr_clr)) |=> flag);
  // R9: defaults after reset
  a_r9_cfg_defaults: assert property (@(posedge clk)
    $past(rst) |-> (fmt == 2'b00 && pad == '0 && !flag));
endmodule

// File: rtl/spi_reg_bridge_port.sv
`timescale 1ns/1ps
module spi_reg_bridge_port #(
  parameter int unsigned ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack,
  output logic              rd_done,
  output logic [31:0]       rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      rd_done   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_done <= 1'b0;
      if ((bus_re || bus_we) && bus_ack) begin
        if (bus_re) begin
          rd_done <= 1'b1;
          rd_data <= bus_rdata;
        end
        bus_re <= 1'b0;
        bus_we <= 1'b0;
      end else if (!(bus_re || bus_we)) begin
        if (start_rd) begin
          bus_re   <= 1'b1;
          bus_addr <= addr;
        end else if (start_wr) begin
          bus_we    <= 1'b1;
          bus_addr  <= addr;
          bus_wdata <= wdata;
        end
      end
    end
  end

  // R3: read request held with a stable address until acknowledged
  a_r3_re_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !bus_ack) |=> (bus_re && $stable(bus_addr)));
  // R2: write request held with stable address and data until acknowledged
  a_r2_we_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_ack) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));
  // R2/R3: never both requests at once
  a_r2_one_request: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
  // R3: read completion only follows an acknowledged read
  a_r3_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(bus_re && bus_ack));
endmodule

// File: rtl/spi_reg_bridge.sv
`timescale 1ns/1ps
module spi_reg_bridge
  import spi_reg_bridge_pkg::*;
#(
  parameter int unsigned HDR_W       = 24,
  parameter int unsigned PAD_W       = 4,
  parameter int unsigned IF_ID       = 2,
  parameter int unsigned CFG_BASE    = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [HDR_W-2:0]  bus_addr,
  output logic [31:0]       bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);
  localparam int unsigned ADDR_W   = HDR_W - 1;
  localparam int unsigned MAX_BITS = HDR_W + 8 * ((1 << PAD_W) - 1) + WORD_W;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(CFG_BASE + 1);
  localparam logic [CNT_W-1:0]  HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(HDR_W + WORD_W - 1);

  // ---------------- pin synchronization and edge detection
  logic [2:0] pins_s;
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;

  spi_reg_bridge_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );
  assign {sclk_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic sck_rise, sck_fall, frame_start;
  assign sck_rise    = sclk_s && !sclk_d && !cs_s;
  assign sck_fall    = !sclk_s && sclk_d && !cs_s;
  assign frame_start = cs_d && !cs_s;

  // ---------------- frame state
  logic [CNT_W-1:0]   cnt;
  logic [HDR_W-2:0]   hdr_sr;
  logic [WORD_W-2:0]  rx_sr;
  logic [WORD_W-1:0]  tx_sr, rbuf, tx_word;
  logic [ADDR_W-1:0]  addr_q;
  logic               is_wr, is_rd, rvalid, miso_q;

  logic [HDR_W-1:0]   hdr_next;
  logic [WORD_W-1:0]  rx_next, wr_word;
  logic [ADDR_W-1:0]  hdr_addr;
  logic               hdr_wr, hdr_local, q_local;
  logic               hdr_done, data_done, pay_start;
  logic [CNT_W-1:0]   load_at;

  // config and bus port
  logic [1:0]       fmt;
  logic [PAD_W-1:0] pad;
  logic             flag;
  logic [31:0]      cfg_rd;
  logic             rd_done;
  logic [31:0]      rd_data;

  assign hdr_next  = {hdr_sr, mosi_s};
  assign rx_next   = {rx_sr, mosi_s};
  assign hdr_wr    = hdr_next[HDR_W-1];
  assign hdr_addr  = hdr_next[ADDR_W-1:0];
  assign hdr_local = (hdr_addr == CTRL_A) || (hdr_addr == STAT_A);
  assign q_local   = (addr_q == CTRL_A) || (addr_q == STAT_A);
  assign hdr_done  = sck_rise && (cnt == HDR_LAST);
  assign data_done = sck_rise && is_wr && (cnt == DATA_LAST);
  assign load_at   = CNT_W'(HDR_W) + CNT_W'({pad, 3'b000});
  assign pay_start = sck_fall && is_rd && (cnt == load_at);
  assign wr_word   = from_wire(fmt, rx_next);
  assign tx_word   = rvalid ? to_wire(fmt, rbuf) : '0;

  spi_reg_bridge_cfg #(.PAD_W(PAD_W), .IF_ID(IF_ID)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(data_done && q_local),
    .wr_stat(addr_q == STAT_A),
    .wr_fmt(wr_word[1:0]),
    .wr_pad(wr_word[PAD_W-1:0]),
    .wr_clr(wr_word[16]),
    .set_flag(pay_start && !rvalid),
    .rd_stat(hdr_addr == STAT_A),
    .fmt(fmt), .pad(pad), .flag(flag),
    .rd_word(cfg_rd)
  );

  spi_reg_bridge_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst),
    .start_rd(hdr_done && !hdr_wr && !hdr_local),
    .start_wr(data_done && !q_local),
    .addr(hdr_done ? hdr_addr : addr_q),
    .wdata(wr_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hdr_sr <= '0;
      rx_sr  <= '0;
      tx_sr  <= '0;
      rbuf   <= '0;
      addr_q <= '0;
      is_wr  <= 1'b0;
      is_rd  <= 1'b0;
      rvalid <= 1'b0;
      miso_q <= 1'b0;
    end else if (cs_s) begin
      is_wr  <= 1'b0;
      is_rd  <= 1'b0;
      miso_q <= 1'b0;
    end else if (frame_start) begin
      cnt    <= '0;
      is_wr  <= 1'b0;
      is_rd  <= 1'b0;
      rvalid <= 1'b0;
      miso_q <= 1'b0;
      tx_sr  <= '0;
    end else begin
      if (sck_rise) begin
        hdr_sr <= hdr_next[HDR_W-2:0];
        rx_sr  <= rx_next[WORD_W-2:0];
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (hdr_done) begin
          addr_q <= hdr_addr;
          is_wr  <= hdr_wr;
          is_rd  <= !hdr_wr;
          if (!hdr_wr && hdr_local) begin
            rbuf   <= cfg_rd;
            rvalid <= 1'b1;
          end
        end
      end
      if (rd_done && is_rd) begin
        rbuf   <= rd_data;
        rvalid <= 1'b1;
      end
      if (sck_fall && is_rd) begin
        if (cnt == load_at) begin
          miso_q <= tx_word[WORD_W-1];
          tx_sr  <= {tx_word[WORD_W-2:0], 1'b0};
        end else if (cnt > load_at) begin
          miso_q <= tx_sr[WORD_W-1];
          tx_sr  <= {tx_sr[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign spi_miso = miso_q;

  // R11: MISO idles low whenever the frame is not selected
  a_r11_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !spi_miso);
  // R8: a new frame always decodes from bit 0
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cnt == '0));
  // R2/R8: a bus write only starts after all data bits of the frame
  a_r8_write_complete: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we) |-> $past(data_done));
  // R3: a bus read only starts right after a header completes
  a_r3_read_on_header: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_re) |-> $past(hdr_done));
  // R10: configuration addresses never reach the bus
  a_r10_local_only: assert property (@(posedge clk) disable iff (rst)
    (bus_re || bus_we) |-> !(bus_addr == CTRL_A || bus_addr == STAT_A));
endmodule

// File: tb/tb_spi_reg_bridge.sv
`timescale 1ns/1ps
module tb_spi_reg_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, bus_ack;

  int total = 0, bad = 0;
  int lat = 2;
  int we_cnt = 0, re_cnt = 0, bc = 0;
  logic [22:0] last_addr;
  logic [31:0] mem [0:63];
  logic [1:0] fmt_b = 2'b00;
  int pad_b = 0;

  always #5 clk = ~clk;

  spi_reg_bridge dut (
    .clk(clk), .rst(rst),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // bus model with run-time latency
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      bus_rdata <= '0;
      bc <= 0;
      last_addr <= '0;
      for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 | 32'(i);
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_re || bus_we) begin
      if (bc >= lat) begin
        bus_ack <= 1'b1;
        bc <= 0;
        last_addr <= bus_addr;
        if (bus_we) begin
          mem[bus_addr[5:0]] <= bus_wdata;
          we_cnt <= we_cnt + 1;
        end else begin
          bus_rdata <= mem[bus_addr[5:0]];
          re_cnt <= re_cnt + 1;
        end
      end else bc <= bc + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // word -> line bits, first bit sent is bit 31
  function automatic logic [31:0] b_ser(input logic [1:0] f, input logic [31:0] w);
    logic [31:0] r;
    logic [7:0] bv;
    r = '0;
    for (int s = 0; s < 4; s++) begin
      bv = f[0] ? w[8*(3-s) +: 8] : w[8*s +: 8];
      if (f[1]) bv = rev8(bv);
      r = {r[23:0], bv};
    end
    return r;
  endfunction

  function automatic logic [31:0] b_deser(input logic [1:0] f, input logic [31:0] l);
    logic [31:0] w;
    logic [7:0] bv;
    w = '0;
    for (int s = 0; s < 4; s++) begin
      bv = l[31-8*s -: 8];
      if (f[1]) bv = rev8(bv);
      if (f[0]) w[8*(3-s) +: 8] = bv;
      else      w[8*s +: 8] = bv;
    end
    return w;
  endfunction

  function automatic logic [31:0] rep_ctrl(input logic [1:0] m);
    return {4{m[0], m[1], 4'b0000, m[1], m[0]}};
  endfunction

  task automatic spi_frame(input logic [255:0] tx, input int n, input int stop_at,
                           output logic [255:0] rx);
    rx = '0;
    cs_n = 1'b0;
    #40;
    for (int i = 0; i < n; i++) begin
      if (i == stop_at) break;
      mosi = tx[n-1-i];
      #40;
      sclk = 1'b1;
      rx[n-1-i] = miso;
      #40;
      sclk = 1'b0;
    end
    mosi = 1'b0;
    #40;
    cs_n = 1'b1;
    #200;
  endtask

  task automatic wr_line(input int addr, input logic [31:0] line, input int stop_at);
    logic [255:0] tx, rx;
    tx = '0;
    tx[55:0] = {1'b1, 23'(addr), line};
    spi_frame(tx, 56, stop_at, rx);
  endtask

  task automatic wr_reg(input int addr, input logic [31:0] d);
    wr_line(addr, b_ser(fmt_b, d), -1);
  endtask

  task automatic rd_reg(input int addr, output logic [31:0] d, output logic quiet);
    logic [255:0] tx, rx;
    int n;
    n = 24 + 8 * pad_b + 32;
    tx = 256'({1'b0, 23'(addr)}) << (n - 24);
    spi_frame(tx, n, -1, rx);
    d = b_deser(fmt_b, rx[31:0]);
    quiet = ((rx >> 32) == '0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, exp, w;
    logic q;
    int a, wc0, rc0;
    logic [1:0] modes [4];
    void'($urandom(32'd1234));
    modes[0] = 2'b01; modes[1] = 2'b11; modes[2] = 2'b10; modes[3] = 2'b00;

    repeat (4) @(posedge clk);
    #2;
    rst = 1'b0;
    #100;
    // R9: idle outputs after reset
    chk("R9 miso after reset", 32'(miso), 32'd0);
    chk("R9 requests after reset", {30'b0, bus_re, bus_we}, 32'd0);
    rd_reg(1, d, q);
    chk("R6/R9 status default", d, 32'h0200_0000);
    rd_reg(0, d, q);
    chk("R5/R9 format default", d, 32'd0);

    // R6: program padding
    wr_reg(1, 32'd2);
    pad_b = 2;
    rd_reg(1, d, q);
    chk("R6 status padding", d, 32'h0200_0002);
    chk("R11 miso low in header/padding", 32'(q), 32'd1);

    // R4/R5: every format, control always sent as format-0 line bits
    for (int mi = 0; mi < 4; mi++) begin
      wc0 = we_cnt;
      rc0 = re_cnt;
      wr_line(0, b_ser(2'b00, rep_ctrl(modes[mi])), -1);
      fmt_b = modes[mi];
      rd_reg(0, d, q);
      chk("R5 replicated format write", d, 32'(modes[mi]));
      chk("R10 config access stays local", 32'(we_cnt + re_cnt), 32'(wc0 + rc0));
      for (int j = 0; j < 4; j++) begin
        a = 2 + int'($urandom_range(61));
        w = $urandom;
        lat = int'($urandom_range(15));
        wr_reg(a, w);
        chk("R2/R4 bus write data", mem[a], w);
        chk("R1 bus address", 32'(last_addr), 32'(a));
        lat = int'($urandom_range(15));
        rd_reg(a, d, q);
        chk("R3/R4 bus read data", d, w);
        chk("R1 read address", 32'(last_addr), 32'(a));
      end
    end

    // R8: aborted write commits nothing, next frame decodes cleanly
    lat = 3;
    exp = mem[10];
    wc0 = we_cnt;
    wr_line(10, b_ser(fmt_b, 32'hDEAD_BEEF), 40);
    chk("R8 aborted write count", 32'(we_cnt), 32'(wc0));
    chk("R8 aborted write data", mem[10], exp);
    wr_line(10, b_ser(fmt_b, 32'h1234_5678), 12);
    rd_reg(10, d, q);
    chk("R8 read after aborts", d, exp);

    // R7: overrun with zero padding and slow bus
    wr_reg(1, 32'd0);
    pad_b = 0;
    lat = 40;
    rd_reg(5, d, q);
    chk("R7 overrun returns zeros", d, 32'd0);
    rd_reg(1, d, q);
    chk("R7 sticky set", d, 32'h0201_0000);
    wr_reg(1, 32'd0);
    rd_reg(1, d, q);
    chk("R7 sticky survives bit16=0 write", d, 32'h0201_0000);
    wr_reg(1, 32'h0001_0001);
    pad_b = 1;
    rd_reg(1, d, q);
    chk("R7 sticky cleared", d, 32'h0200_0001);
    lat = 30;
    exp = mem[5];
    rd_reg(5, d, q);
    chk("R3 read with enough padding", d, exp);
    rd_reg(1, d, q);
    chk("R7 no overrun flagged", d, 32'h0200_0001);

    // R9: reset clears configuration
    wr_line(0, b_ser(2'b00, rep_ctrl(2'b11)), -1);
    fmt_b = 2'b11;
    wr_reg(1, 32'd5);
    pad_b = 5;
    rd_reg(1, d, q);
    chk("R6 padding five", d, 32'h0200_0005);
    rst = 1'b1;
    #100;
    rst = 1'b0;
    #100;
    fmt_b = 2'b00;
    pad_b = 0;
    rd_reg(1, d, q);
    chk("R9 status after reset", d, 32'h0200_0000);
    rd_reg(0, d, q);
    chk("R9 format after reset", d, 32'd0);
    chk("R11 miso idle", 32'(miso), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule